// File: doc/BRIEF.md
# Time-Aligned Flexible Pulse Generator

This block drives a pulse output whose edges are aligned to a system time value made of a seconds count and a subsecond count. Another part of the chip keeps that time value in step with a network time master; this block only reads it. Software loads a target start time, a pulse width and a pulse period through a simple register write port. It then issues a command to produce one pulse or a continuous train of pulses.

The first pulse of a command starts on a compare of the system time against the target. After that, the block times the width and each following period with its own clock-tick counter. It makes no further compare against system time, so a train follows the local clock and not later corrections of the time value. An interrupt strobe marks the moment the target is reached, so a handler can queue the next single pulse while the current one is still high.

With the flexible enable clear, the output instead carries a square wave of 2^f Hz (f from 0 to 14). That wave is taken straight from one bit of a binary subsecond count.

Top module: `flex_pulse_gen`

## Requirements
- R1: While rst_n is low, pulse_out, tgt_irq and err_past are all 0.
- R2: With ctrl bit 0 (address 0) clear, pulse_out equals the inverse of sys_sub bit (SUB_W-1-f), one clock late, where f is ctrl bits 7:4. This gives a 2^f Hz wave that is high in the first half of each period. Values of f above 14 give a constant low.
- R3: Register map: address 0 holds the control bits, 1 the target seconds, 2 the target subseconds, 3 the width and 4 the period. With ctrl bit 0 set, command code 2 arms a single pulse. On the first clock where the system time is at or past the target, pulse_out goes high for width clocks (width of 1 or more, TICK_INC=1) and then returns low.
- R4: tgt_irq is high for exactly one clock, on the same edge where the first pulse of a command rises.
- R5: Command code 3 arms a train. The first pulse starts as in R3, and each later pulse starts period clocks after the previous one. Changes or jumps of the system time after the first pulse do not shift the train.
- R6: In a train whose width is not below the period, each pulse is high for period-1 clocks and low for one clock.
- R7: Command code 4 stops a train. The block goes idle with pulse_out low at the first edge where the output would otherwise be low, so a pulse that is high completes its full width. The same code also cancels an armed, not yet started command.
- R8: A start command whose target is strictly earlier than the system time sets err_past and produces no pulse and no tgt_irq. The next start that arms clears err_past.
- R9: A start command given while a single pulse is high does not shorten that pulse. When the pulse ends, the command is checked and armed against the target registers as they are then.
- R10: Unknown command codes have no effect. Start commands given while armed or during a train are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sys_sec | input | SEC_W | System time, seconds |
| sys_sub | input | SUB_W | System time, subseconds |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | DATA_W | Register write data |
| cmd_valid | input | 1 | Command strobe |
| cmd | input | 4 | Command code (2 single, 3 train, 4 stop) |
| pulse_out | output | 1 | Pulse output |
| tgt_irq | output | 1 | One-clock strobe when the target time is reached |
| err_past | output | 1 | Target was already past at a start |

## Verification
The bench builds the block with binary rollover, SUB_W=16, SEC_W=8 and TICK_INC=1. At these values one simulated second is 65536 clocks. The fixed-mode waves at f=10 and f=14 therefore have periods of 64 and 4 clocks, and targets can be placed a few clocks ahead of the running time. With a tick increment of one, widths and periods map directly to clock counts. This lets the bench jump the system time in the middle of a train and show that the pulse spacing does not move.

// File: rtl/ftg_pkg.sv
package ftg_pkg;
   typedef enum logic [1:0] {ST_IDLE, ST_ARMED, ST_RUN} ftg_state_e;

   localparam logic [3:0] CMD_SINGLE = 4'h2;
   localparam logic [3:0] CMD_TRAIN  = 4'h3;
   localparam logic [3:0] CMD_STOP   = 4'h4;

   localparam logic [2:0] A_CTRL  = 3'd0;
   localparam logic [2:0] A_TSEC  = 3'd1;
   localparam logic [2:0] A_TSUB  = 3'd2;
   localparam logic [2:0] A_WIDTH = 3'd3;
   localparam logic [2:0] A_IVAL  = 3'd4;

   localparam int FSEL_MAX = 14;
endpackage

// File: rtl/ftg_regs.sv
module ftg_regs
   import ftg_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int SEC_W  = 32,
   parameter int SUB_W  = 31
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [2:0]        wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic              flex_en,
   output logic [3:0]        fsel,
   output logic [SEC_W-1:0]  tgt_sec,
   output logic [SUB_W-1:0]  tgt_sub,
   output logic [SUB_W-1:0]  width,
   output logic [SUB_W-1:0]  ival
);
   logic unused_wr;
   assign unused_wr = &{1'b0, wr_data};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flex_en <= 1'b0;
         fsel    <= '0;
         tgt_sec <= '0;
         tgt_sub <= '0;
         width   <= '0;
         ival    <= '0;
      end else if (wr_en) begin
         unique case (wr_addr)
            A_CTRL: begin
               flex_en <= wr_data[0];
               fsel    <= wr_data[7:4];
            end
            A_TSEC:  tgt_sec <= wr_data[SEC_W-1:0];
            A_TSUB:  tgt_sub <= wr_data[SUB_W-1:0];
            A_WIDTH: width   <= wr_data[SUB_W-1:0];
            A_IVAL:  ival    <= wr_data[SUB_W-1:0];
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/ftg_fixed.sv
module ftg_fixed
   import ftg_pkg::*;
#(
   parameter int SUB_W        = 31,
   parameter int DIGITAL_ROLL = 1,
   parameter int ROLL_MAX     = 1000000000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SUB_W-1:0] sys_sub,
   input  logic [3:0]       fsel,
   output logic             fixed_pulse
);
   logic unused_in;
   assign unused_in = &{1'b0, sys_sub, fsel};

   generate
      if (DIGITAL_ROLL != 0) begin : g_bin
         logic sel_bit;
         always_comb begin
            sel_bit = 1'b0;
            for (int k = 0; k <= FSEL_MAX; k++) begin
               if (fsel == 4'(k)) sel_bit = ~sys_sub[SUB_W-1-k];
            end
         end

         always_ff @(posedge clk) begin
            if (!rst_n) fixed_pulse <= 1'b0;
            else        fixed_pulse <= sel_bit;
         end

         // R2: slowest setting follows the top subsecond bit
         a_r2_fixed_one_hz: assert property (@(posedge clk) disable iff (!rst_n)
            (fsel == 4'd0) |=> (fixed_pulse == !$past(sys_sub[SUB_W-1])));
      end else begin : g_dec
         localparam logic [SUB_W-1:0] HALF = SUB_W'(ROLL_MAX / 2);
         always_ff @(posedge clk) begin
            if (!rst_n) fixed_pulse <= 1'b0;
            else        fixed_pulse <= (sys_sub < HALF);
         end
      end
   endgenerate
endmodule

// File: rtl/ftg_seq.sv
module ftg_seq
   import ftg_pkg::*;
#(
   parameter int SEC_W    = 32,
   parameter int SUB_W    = 31,
   parameter int TICK_INC = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SEC_W-1:0] sys_sec,
   input  logic [SUB_W-1:0] sys_sub,
   input  logic             cmd_valid,
   input  logic [3:0]       cmd,
   input  logic [SEC_W-1:0] tgt_sec,
   input  logic [SUB_W-1:0] tgt_sub,
   input  logic [SUB_W-1:0] width,
   input  logic [SUB_W-1:0] ival,
   output logic             pulse,
   output logic             irq,
   output logic             err
);
   localparam int TW    = SEC_W + SUB_W;
   localparam int CNT_W = SUB_W;

   ftg_state_e       state;
   logic [CNT_W-1:0] cnt;
   logic             train, stop_pend, pend, pend_train;

   logic [TW-1:0]    now_t, tgt_t;
   logic             reached, past, is_start, is_stop, start_now, start_train;
   logic [CNT_W-1:0] effw;
   logic [CNT_W:0]   cnt_sum, cnt_wrap;
   logic             p_train, p_single;

   assign now_t       = {sys_sec, sys_sub};
   assign tgt_t       = {tgt_sec, tgt_sub};
   assign reached     = (now_t >= tgt_t);
   assign past        = (tgt_t < now_t);
   assign is_start    = cmd_valid && ((cmd == CMD_SINGLE) || (cmd == CMD_TRAIN));
   assign is_stop     = cmd_valid && (cmd == CMD_STOP);
   assign start_now   = pend || is_start;
   assign start_train = is_start ? (cmd == CMD_TRAIN) : pend_train;

   assign effw     = (width < ival) ? width : ival - 1'b1;
   assign cnt_sum  = {1'b0, cnt} + (CNT_W+1)'(TICK_INC);
   assign cnt_wrap = (cnt_sum >= {1'b0, ival}) ? cnt_sum - {1'b0, ival} : cnt_sum;
   assign p_train  = (cnt_wrap < {1'b0, effw});
   assign p_single = (cnt_sum < {1'b0, width});

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         cnt        <= '0;
         pulse      <= 1'b0;
         irq        <= 1'b0;
         err        <= 1'b0;
         train      <= 1'b0;
         stop_pend  <= 1'b0;
         pend       <= 1'b0;
         pend_train <= 1'b0;
      end else begin
         irq <= 1'b0;
         unique case (state)
            ST_IDLE: if (is_start) begin
               train     <= (cmd == CMD_TRAIN);
               stop_pend <= 1'b0;
               if (past) err <= 1'b1;
               else begin
                  err   <= 1'b0;
                  state <= ST_ARMED;
               end
            end
            ST_ARMED: begin
               if (is_stop) state <= ST_IDLE;
               else if (reached) begin
                  state <= ST_RUN;
                  cnt   <= '0;
                  pulse <= 1'b1;
                  irq   <= 1'b1;
               end
            end
            ST_RUN: begin
               if (train) begin
                  if ((is_stop || stop_pend) && !p_train) begin
                     state     <= ST_IDLE;
                     pulse     <= 1'b0;
                     stop_pend <= 1'b0;
                  end else begin
                     cnt   <= cnt_wrap[CNT_W-1:0];
                     pulse <= p_train;
                     if (is_stop) stop_pend <= 1'b1;
                  end
               end else if (p_single) begin
                  cnt <= cnt_sum[CNT_W-1:0];
                  if (is_start) begin
                     pend       <= 1'b1;
                     pend_train <= (cmd == CMD_TRAIN);
                  end
               end else begin
                  pulse <= 1'b0;
                  pend  <= 1'b0;
                  if (start_now) begin
                     train <= start_train;
                     if (past) begin
                        err   <= 1'b1;
                        state <= ST_IDLE;
                     end else begin
                        err   <= 1'b0;
                        state <= ST_ARMED;
                     end
                  end else state <= ST_IDLE;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // R4: the strobe marks a rising output edge
   a_r4_irq_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (pulse && !$past(pulse)));

   // R3: a first pulse only fires once the time has reached the target
   a_r3_fire_at_target: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> $past(now_t >= tgt_t));

   // R8: a late start raises the error without firing
   a_r8_err_no_fire: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err) |-> (!pulse && !irq));

   // R7: an idle sequencer keeps the output low
   a_r7_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE) |-> !pulse);
endmodule

// File: rtl/flex_pulse_gen.sv
module flex_pulse_gen
   import ftg_pkg::*;
#(
   parameter int DATA_W       = 32,
   parameter int SEC_W        = 32,
   parameter int SUB_W        = 31,
   parameter int DIGITAL_ROLL = 1,
   parameter int ROLL_MAX     = 1000000000,
   parameter int TICK_INC     = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SEC_W-1:0]  sys_sec,
   input  logic [SUB_W-1:0]  sys_sub,
   input  logic              wr_en,
   input  logic [2:0]        wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              cmd_valid,
   input  logic [3:0]        cmd,
   output logic              pulse_out,
   output logic              tgt_irq,
   output logic              err_past
);
   generate
      if (SEC_W > DATA_W || SUB_W > DATA_W) begin : g_bad_width
         $error("time fields must fit in the write data width");
      end
      if (DIGITAL_ROLL != 0 && SUB_W < FSEL_MAX + 1) begin : g_bad_sub
         $error("binary rollover needs at least 15 subsecond bits");
      end
      if (DIGITAL_ROLL == 0 && ((ROLL_MAX - 1) >> SUB_W) != 0) begin : g_bad_roll
         $error("decimal rollover limit does not fit the subsecond field");
      end
      if (TICK_INC < 1) begin : g_bad_tick
         $error("tick increment must be positive");
      end
   endgenerate

   logic             flex_en;
   logic [3:0]       fsel;
   logic [SEC_W-1:0] tgt_sec;
   logic [SUB_W-1:0] tgt_sub, width, ival;
   logic             seq_pulse, fixed_pulse;

   ftg_regs #(.DATA_W(DATA_W), .SEC_W(SEC_W), .SUB_W(SUB_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .flex_en(flex_en), .fsel(fsel), .tgt_sec(tgt_sec), .tgt_sub(tgt_sub),
      .width(width), .ival(ival));

   ftg_fixed #(.SUB_W(SUB_W), .DIGITAL_ROLL(DIGITAL_ROLL), .ROLL_MAX(ROLL_MAX)) u_fixed (
      .clk(clk), .rst_n(rst_n), .sys_sub(sys_sub), .fsel(fsel), .fixed_pulse(fixed_pulse));

   ftg_seq #(.SEC_W(SEC_W), .SUB_W(SUB_W), .TICK_INC(TICK_INC)) u_seq (
      .clk(clk), .rst_n(rst_n), .sys_sec(sys_sec), .sys_sub(sys_sub),
      .cmd_valid(cmd_valid), .cmd(cmd), .tgt_sec(tgt_sec), .tgt_sub(tgt_sub),
      .width(width), .ival(ival), .pulse(seq_pulse), .irq(tgt_irq), .err(err_past));

   assign pulse_out = flex_en ? seq_pulse : fixed_pulse;
endmodule

// File: tb/test_flex_pulse_gen.sv
`timescale 1ns/1ps
module test_flex_pulse_gen;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic        cmd_valid = 1'b0;
   logic [3:0]  cmd = '0;
   logic        pulse_out, tgt_irq, err_past;
   int          t_sys = 0;
   int          jump_amt = 0;
   logic [7:0]  sys_sec;
   logic [15:0] sys_sub;

   assign sys_sec = t_sys[23:16];
   assign sys_sub = t_sys[15:0];

   always #2 clk = ~clk;

   flex_pulse_gen #(.DATA_W(32), .SEC_W(8), .SUB_W(16), .DIGITAL_ROLL(1), .TICK_INC(1)) i_flex_pulse_gen (
      .clk(clk), .rst_n(rst_n), .sys_sec(sys_sec), .sys_sub(sys_sub),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .cmd_valid(cmd_valid), .cmd(cmd),
      .pulse_out(pulse_out), .tgt_irq(tgt_irq), .err_past(err_past));

   int    n_chk = 0, n_fail = 0;
   string cur_req = "R1";
   bit    done = 0;

   always @(negedge clk) begin
      t_sys = t_sys + 1 + jump_amt;
      jump_amt = 0;
   end

   // behavioural reference model: state 0 idle, 1 waiting, 2 running
   int m_flex = 0, m_fsel = 0, m_tsec = 0, m_tsub = 0, m_w = 0, m_iv = 0;
   int m_st = 0, m_cnt = 0, m_pulse = 0, m_irq = 0, m_err = 0, m_fix = 0;
   int m_train = 0, m_stopp = 0, m_pend = 0, m_pt = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_flex = 0; m_fsel = 0; m_tsec = 0; m_tsub = 0; m_w = 0; m_iv = 0;
         m_st = 0; m_cnt = 0; m_pulse = 0; m_irq = 0; m_err = 0; m_fix = 0;
         m_train = 0; m_stopp = 0; m_pend = 0; m_pt = 0;
      end else begin
         int now, tgt, c, ew;
         bit go, stp, hi;
         now = t_sys;
         tgt = m_tsec * 65536 + m_tsub;
         go  = cmd_valid && (cmd == 4'h2 || cmd == 4'h3);
         stp = cmd_valid && (cmd == 4'h4);
         m_irq = 0;
         if (m_st == 0) begin
            if (go) begin
               m_train = (cmd == 4'h3); m_stopp = 0;
               if (tgt < now) m_err = 1; else begin m_err = 0; m_st = 1; end
            end
         end else if (m_st == 1) begin
            if (stp) m_st = 0;
            else if (now >= tgt) begin m_st = 2; m_cnt = 0; m_pulse = 1; m_irq = 1; end
         end else if (m_train != 0) begin
            c = m_cnt + 1;
            if (c >= m_iv) c = c - m_iv;
            ew = (m_w < m_iv) ? m_w : m_iv - 1;
            hi = (c < ew);
            if ((stp || m_stopp != 0) && !hi) begin m_st = 0; m_pulse = 0; m_stopp = 0; end
            else begin m_cnt = c; m_pulse = hi; if (stp) m_stopp = 1; end
         end else begin
            c = m_cnt + 1;
            if (c < m_w) begin
               m_cnt = c;
               if (go) begin m_pend = 1; m_pt = (cmd == 4'h3); end
            end else begin
               m_pulse = 0;
               if (m_pend != 0 || go) begin
                  m_train = go ? (cmd == 4'h3) : m_pt;
                  if (tgt < now) begin m_err = 1; m_st = 0; end
                  else begin m_err = 0; m_st = 1; end
               end else m_st = 0;
               m_pend = 0;
            end
         end
         m_fix = (m_fsel <= 14) ? (((now >> (15 - m_fsel)) & 1) == 0) : 0;
         if (wr_en) begin
            case (wr_addr)
               3'd0: begin m_flex = wr_data[0]; m_fsel = wr_data[7:4]; end
               3'd1: m_tsec = wr_data[7:0];
               3'd2: m_tsub = wr_data[15:0];
               3'd3: m_w = wr_data[15:0];
               3'd4: m_iv = wr_data[15:0];
               default: ;
            endcase
         end
      end
   end

   // per-clock comparison and edge monitor
   int cyc = 0, rises = 0, irqs = 0, rise_cyc = 0, last_period = 0, last_high = 0;
   bit have_rise = 0, prev_p = 0;

   always @(negedge clk) begin
      cyc++;
      if (rst_n) begin
         int exp_p;
         exp_p = (m_flex != 0) ? m_pulse : m_fix;
         n_chk++;
         if (pulse_out !== exp_p[0] || tgt_irq !== m_irq[0] || err_past !== m_err[0]) begin
            n_fail++;
            $display("FAIL %s cycle %0d: pulse/irq/err got %0b%0b%0b expected %0b%0b%0b",
                     cur_req, cyc, pulse_out, tgt_irq, err_past, exp_p[0], m_irq[0], m_err[0]);
         end
         if (pulse_out && !prev_p) begin
            rises++;
            if (have_rise) last_period = cyc - rise_cyc;
            rise_cyc = cyc; have_rise = 1;
         end
         if (!pulse_out && prev_p) last_high = cyc - rise_cyc;
         if (tgt_irq) irqs++;
         prev_p = pulse_out;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: got %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
      #1;
   endtask

   task automatic wr(input logic [2:0] a, input int d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic issue(input logic [3:0] c);
      @(negedge clk);
      cmd_valid = 1'b1; cmd = c;
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic set_tgt(input int d);
      int t;
      t = t_sys + d;
      wr(3'd1, t >> 16);
      wr(3'd2, t & 32'hffff);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog (all requirements): got timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      int base_r, base_i;
      cur_req = "R1";
      repeat (3) @(negedge clk);
      #1;
      chk("R1 pulse_out in reset", pulse_out, 0);
      chk("R1 tgt_irq in reset", tgt_irq, 0);
      chk("R1 err_past in reset", err_past, 0);
      @(negedge clk);
      rst_n = 1'b1;

      cur_req = "R2";
      wr(3'd0, 32'h000000E0);
      wait_clk(40);
      chk("R2 f=14 period", last_period, 4);
      chk("R2 f=14 high time", last_high, 2);
      wr(3'd0, 32'h000000A0);
      wait_clk(300);
      chk("R2 f=10 period", last_period, 64);
      wr(3'd0, 32'h000000F0);
      wait_clk(5);
      base_r = rises;
      wait_clk(200);
      chk("R2 f=15 constant low", rises - base_r, 0);

      cur_req = "R10";
      wr(3'd0, 32'h1);
      wr(3'd3, 5);
      set_tgt(10);
      base_r = rises;
      issue(4'h9);
      wait_clk(40);
      chk("R10 unknown code gives no pulse", rises - base_r, 0);

      cur_req = "R3";
      set_tgt(20);
      base_r = rises; base_i = irqs;
      issue(4'h2);
      issue(4'h3);
      wait_clk(60);
      chk("R3 single pulse count", rises - base_r, 1);
      chk("R3 single pulse width", last_high, 5);
      chk("R4 one strobe per command", irqs - base_i, 1);

      cur_req = "R8";
      set_tgt(-50);
      base_r = rises;
      issue(4'h2);
      wait_clk(10);
      chk("R8 late start flags error", err_past, 1);
      chk("R8 late start gives no pulse", rises - base_r, 0);
      set_tgt(20);
      issue(4'h2);
      wait_clk(3);
      chk("R8 good start clears error", err_past, 0);
      wait_clk(40);

      cur_req = "R9";
      wr(3'd3, 30);
      set_tgt(10);
      base_r = rises; base_i = irqs;
      issue(4'h2);
      while (!tgt_irq) @(negedge clk);
      set_tgt(60);
      issue(4'h2);
      wait_clk(20);
      chk("R9 first pulse not shortened", pulse_out, 1);
      wait_clk(100);
      chk("R9 queued pulse fired", rises - base_r, 2);
      chk("R9 queued pulse width", last_high, 30);
      chk("R4 strobe per command", irqs - base_i, 2);

      cur_req = "R5";
      wr(3'd3, 4);
      wr(3'd4, 10);
      set_tgt(10);
      base_i = irqs;
      issue(4'h3);
      wait_clk(60);
      chk("R5 train period", last_period, 10);
      chk("R5 train width", last_high, 4);
      @(posedge clk);
      jump_amt = 3000;
      wait_clk(45);
      chk("R5 period after time jump", last_period, 10);
      chk("R4 single strobe for whole train", irqs - base_i, 1);
      cur_req = "R10";
      issue(4'h2);
      wait_clk(30);
      chk("R10 start during train ignored", last_period, 10);

      cur_req = "R7";
      while (!pulse_out) @(negedge clk);
      issue(4'h4);
      wait_clk(4);
      base_r = rises;
      wait_clk(30);
      chk("R7 stop ends train", rises - base_r, 0);
      chk("R7 pulse in flight completes", last_high, 4);
      chk("R7 output low after stop", pulse_out, 0);

      set_tgt(10);
      issue(4'h3);
      wait_clk(20);
      while (pulse_out) @(negedge clk);
      issue(4'h4);
      base_r = rises;
      wait_clk(30);
      chk("R7 stop while low ends at once", rises - base_r, 0);

      cur_req = "R6";
      wr(3'd3, 12);
      wr(3'd4, 8);
      set_tgt(10);
      issue(4'h3);
      wait_clk(50);
      chk("R6 capped high time", last_high, 7);
      chk("R6 period kept", last_period, 8);
      while (!pulse_out) @(negedge clk);
      issue(4'h4);
      wait_clk(20);
      chk("R6 stopped low", pulse_out, 0);

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule